// File: doc/BRIEF.md
# Profile-Based RAM Playback Sequencer

This block holds a small waveform memory and a bank of eight playback profiles. Each profile has a first address, a last address and a rate divider. A 3-bit input selects the active profile, and a 3-bit mode code sets how an address counter walks the memory. The addressed word goes out together with a 2-bit tag that names the synthesis parameter it drives. Software, or any other master, fills the memory and the profile bank through plain write strobes. It then picks a mode and a profile and raises `play_en`. Dropping `play_en` returns the block to idle.

The control state machine has five states. ST_IDLE waits for `play_en`. On enable it checks the mode and moves along one of three transitions. "reject" goes to ST_ERR. "hold" goes to ST_HOLD, which is direct-switch output. "launch" goes to ST_RUN, where the address steps. From ST_RUN the "finish" transition leads to ST_DONE when a one-shot mode reaches its end. The "drop" transition returns to ST_IDLE from any state once `play_en` is low. While in ST_RUN, each step comes from a rate tick. When a profile holds divider value d, each address stays on the output for d+1 clocks. The sequenced modes play profiles 0 through X back to back, where X is the active profile. Each profile in the run uses its own range and its own rate.

Top module: `ram_profile_player`

## Requirements
- R1: After reset, and with `play_en` low, `word_valid`, `done` and `mode_err` are 0 and `word_out` is 0.
- R2: Mode code 0 (direct switch) outputs the memory word at the first address of the active profile. If `active_prof` changes, the output follows one clock later. `done` never rises in this mode.
- R3: In the stepping modes (codes 1 to 6), a profile with divider value d keeps each address on the output for d+1 clocks. The first address appears one clock after `play_en` is seen high.
- R4: Mode code 1 (one-shot ramp) steps from the first to the last address of the active profile. After the last address has had its full d+1 clocks, `done` rises and the last word stays on the output while `play_en` stays high.
- R5: Mode code 4 (looping ramp) steps upward and returns to the first address after the last one, without ever raising `done`.
- R6: Mode code 2 (pin-steered ramp) steps up while `dir_up` is 1 and down while it is 0. It halts at the range limits instead of wrapping.
- R7: Mode code 3 (triangle sweep) reverses direction at each range limit and does not stop. For range 4..6 it gives 4,5,6,5,4,5,6.
- R8: Mode code 5 (one-shot sequence) plays profiles 0, 1, … up to the active profile X. Each profile uses its own range and divider. `play_prof` reports the profile being played. `done` rises after profile X ends.
- R9: Mode code 6 (looping sequence) behaves like code 5 except that profile 0 starts again after profile X.
- R10: On enable, a sequence mode with active profile 0, or the reserved code 7, is rejected. `mode_err` becomes 1 and `word_valid` stays 0.
- R11: `dest_out` takes the value of `dest_in` when playback is enabled and ignores later changes of `dest_in`. The tag values are 0 polar, 1 frequency, 2 phase and 3 amplitude.
- R12: Lowering `play_en` returns the block to idle on the next clock, with `word_valid`, `done` and `mode_err` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_we | input | 1 | Waveform memory write strobe |
| ram_waddr | input | AW | Waveform memory write address |
| ram_wdata | input | DW | Waveform memory write data |
| prof_we | input | 1 | Profile register write strobe |
| prof_sel | input | 3 | Profile being written |
| prof_first | input | AW | First address of the written profile |
| prof_last | input | AW | Last address of the written profile |
| prof_div | input | DIVW | Rate divider of the written profile |
| active_prof | input | 3 | Active profile index |
| mode_in | input | 3 | Playback mode code |
| dest_in | input | 2 | Destination tag captured on enable |
| play_en | input | 1 | Playback enable (level) |
| dir_up | input | 1 | Direction pin for mode code 2 |
| word_out | output | DW | Current memory word, 0 when not valid |
| dest_out | output | 2 | Captured destination tag |
| word_valid | output | 1 | Word output is live |
| play_prof | output | 3 | Profile currently being played |
| done | output | 1 | One-shot playback finished |
| mode_err | output | 1 | Enable was rejected |

## Verification
Some properties are checked on every cycle. An address never moves without a rate tick. The sequence index never passes the active profile. `done` appears only in one-shot modes and holds the address frozen. A rejected enable always raises the error flag. Dropping the enable always clears the outputs, and the tag stays fixed while a word is live. The bench scenarios cover what needs a whole trajectory: the exact address order for each mode, the dwell of d+1 clocks, reversal and wrap points, the handover between profiles in a sequence, and how the direction pin steers the ramp.

// File: rtl/rpp_pkg.sv
package rpp_pkg;
    localparam int NPROF = 8;
    localparam int PIW   = 3;

    typedef enum logic [2:0] {
        MD_DIRECT     = 3'd0,
        MD_RAMP_ONE   = 3'd1,
        MD_BIDIR_PIN  = 3'd2,
        MD_BIDIR_CONT = 3'd3,
        MD_RAMP_CONT  = 3'd4,
        MD_SEQ_ONE    = 3'd5,
        MD_SEQ_CONT   = 3'd6,
        MD_RSVD       = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RUN,
        ST_DONE,
        ST_ERR
    } state_e;

    function automatic logic is_seq(mode_e m);
        return (m == MD_SEQ_ONE) || (m == MD_SEQ_CONT);
    endfunction
endpackage

// File: rtl/rpp_wave_ram.sv
module rpp_wave_ram #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rpp_profile_bank.sv
module rpp_profile_bank
    import rpp_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DIVW = 8,
    parameter int NRD  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [PIW-1:0]            wsel,
    input  logic [AW-1:0]             wfirst,
    input  logic [AW-1:0]             wlast,
    input  logic [DIVW-1:0]           wdiv,
    input  logic [NRD-1:0][PIW-1:0]   rd_idx,
    output logic [NRD-1:0][AW-1:0]    rd_first,
    output logic [NRD-1:0][AW-1:0]    rd_last,
    output logic [NRD-1:0][DIVW-1:0]  rd_div
);
    logic [AW-1:0]   first_q [NPROF];
    logic [AW-1:0]   last_q  [NPROF];
    logic [DIVW-1:0] div_q   [NPROF];

    for (genvar p = 0; p < NPROF; p++) begin : g_prof
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                first_q[p] <= '0;
                last_q[p]  <= '0;
                div_q[p]   <= '0;
            end else if (we && (wsel == PIW'(p))) begin
                first_q[p] <= wfirst;
                last_q[p]  <= wlast;
                div_q[p]   <= wdiv;
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_first[r] = first_q[rd_idx[r]];
        assign rd_last[r]  = last_q[rd_idx[r]];
        assign rd_div[r]   = div_q[rd_idx[r]];
    end
endmodule

// File: rtl/rpp_rate_div.sv
module rpp_rate_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = !clear && (cnt_q >= reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clear || tick)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // R3: after a step the dwell count starts over
    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/ram_profile_player.sv
module ram_profile_player
    import rpp_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 16,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ram_we,
    input  logic [AW-1:0]   ram_waddr,
    input  logic [DW-1:0]   ram_wdata,
    input  logic            prof_we,
    input  logic [2:0]      prof_sel,
    input  logic [AW-1:0]   prof_first,
    input  logic [AW-1:0]   prof_last,
    input  logic [DIVW-1:0] prof_div,
    input  logic [2:0]      active_prof,
    input  logic [2:0]      mode_in,
    input  logic [1:0]      dest_in,
    input  logic            play_en,
    input  logic            dir_up,
    output logic [DW-1:0]   word_out,
    output logic [1:0]      dest_out,
    output logic            word_valid,
    output logic [2:0]      play_prof,
    output logic            done,
    output logic            mode_err
);
    localparam int NRD    = 3;
    localparam int RP_CUR = 0;
    localparam int RP_SEL = 1;
    localparam int RP_NXT = 2;

    state_e         state_q, state_d;
    mode_e          mode_q, mode_d, mode_req;
    logic [PIW-1:0] cur_q, cur_d, last_q, last_d;
    logic [AW-1:0]  addr_q, addr_d;
    logic           up_q, up_d;
    logic [1:0]     dest_q, dest_d;

    logic [NRD-1:0][PIW-1:0]  rd_idx;
    logic [NRD-1:0][AW-1:0]   rd_first, rd_last;
    logic [NRD-1:0][DIVW-1:0] rd_div;
    logic                     tick;
    logic [DW-1:0]            ram_rdata;
    logic                     bad_req;

    assign mode_req = mode_e'(mode_in);
    assign bad_req  = (mode_req == MD_RSVD) ||
                      (is_seq(mode_req) && (active_prof == '0));

    assign rd_idx[RP_CUR] = cur_q;
    assign rd_idx[RP_SEL] = (state_q == ST_IDLE && is_seq(mode_req)) ? '0 : active_prof;
    assign rd_idx[RP_NXT] = (cur_q == last_q) ? '0 : cur_q + 1'b1;

    rpp_profile_bank #(.AW(AW), .DIVW(DIVW), .NRD(NRD)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (prof_we),
        .wsel     (prof_sel),
        .wfirst   (prof_first),
        .wlast    (prof_last),
        .wdiv     (prof_div),
        .rd_idx   (rd_idx),
        .rd_first (rd_first),
        .rd_last  (rd_last),
        .rd_div   (rd_div)
    );

    rpp_rate_div #(.W(DIVW)) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q != ST_RUN),
        .reload (rd_div[RP_CUR]),
        .tick   (tick)
    );

    rpp_wave_ram #(.AW(AW), .DW(DW)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (addr_q),
        .rdata (ram_rdata)
    );

    // next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        cur_d   = cur_q;
        last_d  = last_q;
        addr_d  = addr_q;
        up_d    = up_q;
        dest_d  = dest_q;
        if (!play_en) begin
            state_d = ST_IDLE;                      // drop
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    mode_d = mode_req;
                    last_d = active_prof;
                    dest_d = dest_in;
                    up_d   = 1'b1;
                    cur_d  = rd_idx[RP_SEL];
                    addr_d = rd_first[RP_SEL];
                    if (bad_req)                    state_d = ST_ERR;   // reject
                    else if (mode_req == MD_DIRECT) state_d = ST_HOLD;  // hold
                    else                            state_d = ST_RUN;   // launch
                end
                ST_HOLD: begin
                    cur_d  = active_prof;
                    addr_d = rd_first[RP_SEL];
                end
                ST_RUN: begin
                    if (tick) begin
                        unique case (mode_q)
                            MD_RAMP_ONE: begin
                                if (addr_q == rd_last[RP_CUR]) state_d = ST_DONE; // finish
                                else addr_d = addr_q + 1'b1;
                            end
                            MD_RAMP_CONT: begin
                                if (addr_q == rd_last[RP_CUR]) addr_d = rd_first[RP_CUR];
                                else addr_d = addr_q + 1'b1;
                            end
                            MD_BIDIR_PIN: begin
                                if (dir_up) begin
                                    if (addr_q != rd_last[RP_CUR]) addr_d = addr_q + 1'b1;
                                end else begin
                                    if (addr_q != rd_first[RP_CUR]) addr_d = addr_q - 1'b1;
                                end
                            end
                            MD_BIDIR_CONT: begin
                                if (up_q) begin
                                    if (addr_q != rd_last[RP_CUR]) addr_d = addr_q + 1'b1;
                                    else begin
                                        up_d = 1'b0;
                                        if (addr_q != rd_first[RP_CUR]) addr_d = addr_q - 1'b1;
                                    end
                                end else begin
                                    if (addr_q != rd_first[RP_CUR]) addr_d = addr_q - 1'b1;
                                    else begin
                                        up_d = 1'b1;
                                        if (addr_q != rd_last[RP_CUR]) addr_d = addr_q + 1'b1;
                                    end
                                end
                            end
                            MD_SEQ_ONE, MD_SEQ_CONT: begin
                                if (addr_q != rd_last[RP_CUR]) begin
                                    addr_d = addr_q + 1'b1;
                                end else if (cur_q == last_q && mode_q == MD_SEQ_ONE) begin
                                    state_d = ST_DONE;                                 // finish
                                end else begin
                                    cur_d  = rd_idx[RP_NXT];
                                    addr_d = rd_first[RP_NXT];
                                end
                            end
                            MD_DIRECT, MD_RSVD: ;
                        endcase
                    end
                end
                ST_DONE, ST_ERR: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MD_DIRECT;
            cur_q   <= '0;
            last_q  <= '0;
            addr_q  <= '0;
            up_q    <= 1'b1;
            dest_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
            addr_q  <= addr_d;
            up_q    <= up_d;
            dest_q  <= dest_d;
        end
    end

    // outputs
    always_comb begin
        word_valid = (state_q == ST_RUN) || (state_q == ST_HOLD) || (state_q == ST_DONE);
        done       = (state_q == ST_DONE);
        mode_err   = (state_q == ST_ERR);
        word_out   = word_valid ? ram_rdata : '0;
        dest_out   = dest_q;
        play_prof  = cur_q;
    end

    // R10: invalid requests always end in the error state
    p_reject_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && play_en && bad_req) |=> (mode_err && !word_valid));

    // R12: releasing the enable clears every flag on the next clock
    p_drop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> (!word_valid && !done && !mode_err));

    // R4: once finished, the address is frozen
    p_done_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && play_en) |=> (done && $stable(addr_q)));

    // R4: completion exists only for one-shot modes
    p_done_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_q == MD_RAMP_ONE || mode_q == MD_SEQ_ONE));

    // R3: no address or profile movement without a rate tick
    p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && play_en && !tick) |=> ($stable(addr_q) && $stable(cur_q)));

    // R8: sequencing never passes the active profile
    p_seq_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && is_seq(mode_q)) |-> (cur_q <= last_q));

    // R11: the tag holds while a word is live
    p_dest_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && play_en) |=> $stable(dest_out));
endmodule

// File: tb/test_ram_profile_player.sv
module test_ram_profile_player;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6, DW = 16, DIVW = 8;

    logic            clk = 0, rst_n = 0;
    logic            ram_we = 0;
    logic [AW-1:0]   ram_waddr = '0;
    logic [DW-1:0]   ram_wdata = '0;
    logic            prof_we = 0;
    logic [2:0]      prof_sel = '0;
    logic [AW-1:0]   prof_first = '0, prof_last = '0;
    logic [DIVW-1:0] prof_div = '0;
    logic [2:0]      active_prof = '0, mode_in = '0;
    logic [1:0]      dest_in = '0;
    logic            play_en = 0, dir_up = 1;
    logic [DW-1:0]   word_out;
    logic [1:0]      dest_out;
    logic            word_valid, done, mode_err;
    logic [2:0]      play_prof;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ram_profile_player #(.AW(AW), .DW(DW), .DIVW(DIVW)) i_ram_profile_player (
        .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .prof_we(prof_we), .prof_sel(prof_sel), .prof_first(prof_first), .prof_last(prof_last),
        .prof_div(prof_div), .active_prof(active_prof), .mode_in(mode_in), .dest_in(dest_in),
        .play_en(play_en), .dir_up(dir_up), .word_out(word_out), .dest_out(dest_out),
        .word_valid(word_valid), .play_prof(play_prof), .done(done), .mode_err(mode_err)
    );

    function automatic logic [DW-1:0] rv(int a);
        return 16'hC000 + 16'(a * 3);
    endfunction

    task automatic ck(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // check current word against memory address a, then advance one clock
    task automatic cw(string req, int a);
        ck(req, 32'(word_out), 32'(rv(a)));
        @(negedge clk);
    endtask

    task automatic set_prof(int p, int f, int l, int d);
        @(negedge clk);
        prof_we = 1; prof_sel = 3'(p); prof_first = AW'(f); prof_last = AW'(l); prof_div = DIVW'(d);
        @(negedge clk);
        prof_we = 0;
    endtask

    task automatic start_play(int md, int act, int dst);
        @(negedge clk);
        play_en = 0;
        @(negedge clk);
        mode_in = 3'(md); active_prof = 3'(act); dest_in = 2'(dst); play_en = 1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        ck("R1 valid", 32'(word_valid), 0);
        ck("R1 done", 32'(done), 0);
        ck("R1 err", 32'(mode_err), 0);
        ck("R1 word", 32'(word_out), 0);
    endtask

    task automatic t_direct;
        set_prof(5, 9, 20, 0);
        set_prof(6, 12, 30, 0);
        start_play(0, 5, 1);
        ck("R2 valid", 32'(word_valid), 1);
        cw("R2 start5", 9);
        cw("R2 hold", 9);
        active_prof = 3'd6;
        @(negedge clk);
        ck("R2 follow", 32'(word_out), 32'(rv(12)));
        ck("R2 nodone", 32'(done), 0);
    endtask

    task automatic t_ramp_one;
        set_prof(1, 4, 7, 1);
        start_play(1, 1, 2);
        for (int a = 4; a <= 7; a++) begin
            cw("R3 R4 dwell0", a);
            ck("R4 nodone", 32'(done), 0);
            cw("R3 R4 dwell1", a);
        end
        ck("R4 done", 32'(done), 1);
        cw("R4 lastword", 7);
        cw("R4 lastword hold", 7);
        ck("R4 done hold", 32'(done), 1);
    endtask

    task automatic t_ramp_cont;
        set_prof(1, 4, 6, 0);
        start_play(4, 1, 0);
        cw("R5", 4); cw("R5", 5);
        dest_in = 2'd3;
        cw("R5", 6); cw("R5 wrap", 4); cw("R5", 5);
        ck("R5 nodone", 32'(done), 0);
        ck("R11 polar kept", 32'(dest_out), 0);
        start_play(4, 1, 2);
        ck("R11 phase", 32'(dest_out), 2);
    endtask

    task automatic t_bidir_pin;
        set_prof(3, 4, 7, 0);
        dir_up = 1;
        start_play(2, 3, 3);
        cw("R6 up", 4); cw("R6 up", 5); cw("R6 up", 6); cw("R6 up", 7);
        ck("R6 dwell hi", 32'(word_out), 32'(rv(7)));
        dir_up = 0;
        @(negedge clk);
        cw("R6 down", 6); cw("R6 down", 5); cw("R6 down", 4);
        cw("R6 dwell lo", 4);
        dir_up = 1;
    endtask

    task automatic t_bidir_cont;
        set_prof(1, 4, 6, 0);
        start_play(3, 1, 1);
        cw("R7", 4); cw("R7", 5); cw("R7", 6); cw("R7 rev", 5);
        cw("R7", 4); cw("R7 rev", 5); cw("R7", 6);
    endtask

    task automatic seq_profiles;
        set_prof(0, 0, 1, 0);
        set_prof(1, 2, 3, 1);
        set_prof(2, 8, 8, 0);
    endtask

    task automatic t_seq_one;
        seq_profiles();
        start_play(5, 2, 1);
        ck("R8 prof0", 32'(play_prof), 0);
        cw("R8", 0); cw("R8", 1);
        ck("R8 prof1", 32'(play_prof), 1);
        cw("R8", 2); cw("R8", 2); cw("R8", 3); cw("R8", 3);
        ck("R8 prof2", 32'(play_prof), 2);
        ck("R8 nodone", 32'(done), 0);
        cw("R8", 8);
        ck("R8 done", 32'(done), 1);
        ck("R8 lastword", 32'(word_out), 32'(rv(8)));
    endtask

    task automatic t_seq_cont;
        seq_profiles();
        start_play(6, 2, 1);
        cw("R9", 0); cw("R9", 1); cw("R9", 2); cw("R9", 2);
        cw("R9", 3); cw("R9", 3); cw("R9", 8);
        ck("R9 back0", 32'(play_prof), 0);
        cw("R9 wrap", 0); cw("R9", 1);
        ck("R9 nodone", 32'(done), 0);
    endtask

    task automatic t_reject;
        start_play(5, 0, 1);
        ck("R10 seq x0 err", 32'(mode_err), 1);
        ck("R10 seq x0 valid", 32'(word_valid), 0);
        start_play(7, 3, 1);
        ck("R10 rsvd err", 32'(mode_err), 1);
        play_en = 0;
        @(negedge clk);
        ck("R12 err clear", 32'(mode_err), 0);
    endtask

    task automatic t_drop;
        set_prof(1, 4, 5, 0);
        start_play(1, 1, 0);
        @(negedge clk); @(negedge clk);
        ck("R12 pre done", 32'(done), 1);
        play_en = 0;
        @(negedge clk);
        ck("R12 done", 32'(done), 0);
        ck("R12 valid", 32'(word_valid), 0);
        ck("R12 word", 32'(word_out), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            ram_we = 1; ram_waddr = AW'(a); ram_wdata = rv(a);
        end
        @(negedge clk);
        ram_we = 0;
        t_reset();
        t_direct();
        t_ramp_one();
        t_ramp_cont();
        t_bidir_pin();
        t_bidir_cont();
        t_seq_one();
        t_seq_cont();
        t_reject();
        t_drop();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule